// File: doc/BRIEF.md
# Multichannel Codec Frame Controller

This block sits between a host processor bus and a bank of stereo serial codecs that run in lockstep. After reset it keeps every codec in reset, so none of them samples. Software starts the bank, or stops it, by writing one control word. A single register drives every codec reset line, so the whole bank changes state in the same clock.

While the bank runs, the block follows the two serial phases of each frame. The left burst comes first and the right burst follows. Each phase lasts a fixed number of clock cycles, taken from the ratio between the codec master clock and the sample rate. At the end of each phase the block raises an interrupt pulse of fixed width, meant to be caught on its rising edge. It also records which phase's channel buffer the host may now touch. The host reads that flag, and the live interrupt level, at the control address.

Top module: `codec_frame_ctrl`

## Requirements
- R1: While reset is held and in the cycle after it ends, every bit of `codec_rst` is 1, `irq` is 0 and `bus_rdata` is 0.
- R2: A write that has `bus_wr` and `bus_strb` high, `bus_addr` equal to CTRL_ADDR and `bus_wdata` bit 7 set drives every `codec_rst` bit to 0 in the cycle after the write edge. All bits change in the same cycle.
- R3: A write of the same kind with bit 7 clear drives every `codec_rst` bit back to 1 in the cycle after the write edge.
- R4: A write to any other address, or a write made with `bus_strb` low, leaves `codec_rst` unchanged.
- R5: After a start write, the first interrupt rises PHASE_CYCLES+1 clock edges after the write edge. While the bank keeps running, later rises follow every PHASE_CYCLES cycles.
- R6: Each interrupt pulse stays high for exactly IRQ_WIDTH clock cycles (default 6, which is 120 ns at 50 MHz).
- R7: The first interrupt after a start marks the left phase, with status bit 1 = 0. The next one marks the right phase, with status bit 1 = 1, and the two alternate from then on.
- R8: A read with `bus_rd` and `bus_strb` high and `bus_addr` equal to CTRL_ADDR returns, one cycle later, bit 0 = the `irq` level at the read edge and bit 1 = the accessible phase (0 = left, 1 = right). All other bits are 0. Any other read returns 0.
- R9: A stop returns phase tracking to its left start state. A later restart again produces a left interrupt first, PHASE_CYCLES+1 edges after the start write. While the bank is stopped no new interrupt starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W | Host address |
| bus_wdata | input | DATA_W | Host write data; bit 7 is the run command |
| bus_wr | input | 1 | Host write enable |
| bus_rd | input | 1 | Host read enable |
| bus_strb | input | 1 | Dedicated strobe that qualifies access to the control address |
| bus_rdata | output | DATA_W | Registered status read data |
| codec_rst | output | NUM_CODECS | Active-high reset to each codec |
| irq | output | 1 | End-of-phase interrupt pulse |

## Verification
On every cycle the in-RTL assertions check how writes act on the run state: starting, stopping and ignoring writes that miss the address or the strobe. They also check that a stopped tracker sits at its left start state, that a pulse starts on each phase end and never outlives its width counter, and that a read miss returns zero. Some behaviours show only in whole scenarios, and only the bench's checks can confirm them. These are the exact latency from a start write to the first interrupt, the period between interrupts, the pulse width seen at the pin, the left-then-right order reported in status, and a left-first restart after a stop made partway through a frame.

// File: rtl/cfc_pkg.sv
package cfc_pkg;
  localparam int RUN_BIT      = 7;
  localparam int ST_IRQ_BIT   = 0;
  localparam int ST_PHASE_BIT = 1;

  typedef enum logic {
    PH_LEFT  = 1'b0,
    PH_RIGHT = 1'b1
  } phase_e;
endpackage

// File: rtl/cfc_host_regs.sv
module cfc_host_regs
  import cfc_pkg::*;
#(
  parameter int          ADDR_W    = 32,
  parameter int          DATA_W    = 32,
  parameter logic [31:0] CTRL_ADDR = 32'h8020_0020
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              wr,
  input  logic              rd,
  input  logic              strb,
  input  logic              irq_lvl,
  input  phase_e            avail,
  output logic              run_o,
  output logic [DATA_W-1:0] rdata_o
);
  localparam logic [ADDR_W-1:0] MATCH = ADDR_W'(CTRL_ADDR);

  logic sel, wr_hit, rd_hit;
  logic run_q;
  logic [DATA_W-1:0] rdata_q, status;

  assign sel    = strb && (addr == MATCH);
  assign wr_hit = sel && wr;
  assign rd_hit = sel && rd;

  always_comb begin
    status               = '0;
    status[ST_IRQ_BIT]   = irq_lvl;
    status[ST_PHASE_BIT] = avail;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q   <= 1'b0;
      rdata_q <= '0;
    end else begin
      if (wr_hit) run_q <= wdata[RUN_BIT];
      rdata_q <= rd_hit ? status : '0;
    end
  end

  assign run_o   = run_q;
  assign rdata_o = rdata_q;

  p_start_r2: assert property (@(posedge clk) disable iff (rst)
    (wr_hit && wdata[RUN_BIT]) |=> run_q);
  p_stop_r3: assert property (@(posedge clk) disable iff (rst)
    (wr_hit && !wdata[RUN_BIT]) |=> !run_q);
  p_ignore_r4: assert property (@(posedge clk) disable iff (rst)
    !wr_hit |=> $stable(run_q));
  p_read_miss_r8: assert property (@(posedge clk) disable iff (rst)
    !rd_hit |=> (rdata_q == '0));
endmodule

// File: rtl/cfc_phase_tracker.sv
module cfc_phase_tracker
  import cfc_pkg::*;
#(
  parameter int PHASE_CYCLES = 512
) (
  input  logic   clk,
  input  logic   rst,
  input  logic   run,
  output logic   end_stb,
  output phase_e avail
);
  localparam int          CW   = (PHASE_CYCLES > 1) ? $clog2(PHASE_CYCLES) : 1;
  localparam logic [CW-1:0] LAST = CW'(PHASE_CYCLES - 1);

  logic [CW-1:0] cnt_q;
  phase_e        cur_q, avail_q;
  logic          end_q;

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      cnt_q   <= '0;
      cur_q   <= PH_LEFT;
      avail_q <= PH_LEFT;
      end_q   <= 1'b0;
    end else if (cnt_q == LAST) begin
      cnt_q   <= '0;
      end_q   <= 1'b1;
      avail_q <= cur_q;
      cur_q   <= (cur_q == PH_LEFT) ? PH_RIGHT : PH_LEFT;
    end else begin
      cnt_q <= cnt_q + 1'b1;
      end_q <= 1'b0;
    end
  end

  assign end_stb = end_q;
  assign avail   = avail_q;

  p_idle_left_r9: assert property (@(posedge clk) disable iff (rst)
    !run |=> (cnt_q == '0 && cur_q == PH_LEFT && !end_q));
  p_single_end_r5: assert property (@(posedge clk) disable iff (rst)
    end_q |=> !end_q);
  p_alternate_r7: assert property (@(posedge clk) disable iff (rst)
    (end_q && run) |=> (avail_q != cur_q || !run || end_q));
endmodule

// File: rtl/cfc_irq_shaper.sv
module cfc_irq_shaper #(
  parameter int IRQ_WIDTH = 6
) (
  input  logic clk,
  input  logic rst,
  input  logic trig,
  output logic irq_o
);
  localparam int WW = (IRQ_WIDTH > 1) ? $clog2(IRQ_WIDTH) : 1;

  logic [WW-1:0] rem_q;
  logic          irq_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_q <= 1'b0;
      rem_q <= '0;
    end else if (trig) begin
      irq_q <= 1'b1;
      rem_q <= WW'(IRQ_WIDTH - 1);
    end else if (irq_q) begin
      if (rem_q == '0) irq_q <= 1'b0;
      else             rem_q <= rem_q - 1'b1;
    end
  end

  assign irq_o = irq_q;

  p_pulse_start_r6: assert property (@(posedge clk) disable iff (rst)
    trig |=> irq_q);
  p_pulse_bound_r6: assert property (@(posedge clk) disable iff (rst)
    (irq_q && rem_q == '0 && !trig) |=> !irq_q);
endmodule

// File: rtl/codec_frame_ctrl.sv
module codec_frame_ctrl
  import cfc_pkg::*;
#(
  parameter int          NUM_CODECS   = 16,
  parameter int          ADDR_W       = 32,
  parameter int          DATA_W       = 32,
  parameter logic [31:0] CTRL_ADDR    = 32'h8020_0020,
  parameter int          PHASE_CYCLES = 512,
  parameter int          IRQ_WIDTH    = 6
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [ADDR_W-1:0]     bus_addr,
  input  logic [DATA_W-1:0]     bus_wdata,
  input  logic                  bus_wr,
  input  logic                  bus_rd,
  input  logic                  bus_strb,
  output logic [DATA_W-1:0]     bus_rdata,
  output logic [NUM_CODECS-1:0] codec_rst,
  output logic                  irq
);
  initial begin
    if (PHASE_CYCLES <= IRQ_WIDTH + 1)
      $error("PHASE_CYCLES must exceed IRQ_WIDTH + 1");
    if (IRQ_WIDTH < 1)
      $error("IRQ_WIDTH must be at least 1");
  end

  logic   run;
  logic   end_stb;
  phase_e avail;
  logic   irq_lvl;

  cfc_host_regs #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CTRL_ADDR(CTRL_ADDR)
  ) u_regs (
    .clk(clk), .rst(rst), .addr(bus_addr), .wdata(bus_wdata),
    .wr(bus_wr), .rd(bus_rd), .strb(bus_strb),
    .irq_lvl(irq_lvl), .avail(avail),
    .run_o(run), .rdata_o(bus_rdata)
  );

  cfc_phase_tracker #(.PHASE_CYCLES(PHASE_CYCLES)) u_track (
    .clk(clk), .rst(rst), .run(run), .end_stb(end_stb), .avail(avail)
  );

  cfc_irq_shaper #(.IRQ_WIDTH(IRQ_WIDTH)) u_irq (
    .clk(clk), .rst(rst), .trig(end_stb), .irq_o(irq_lvl)
  );

  for (genvar g = 0; g < NUM_CODECS; g++) begin : g_codec_rst
    assign codec_rst[g] = ~run;
  end

  assign irq = irq_lvl;

  p_no_irq_start_stopped_r9: assert property (@(posedge clk) disable iff (rst)
    (!run && !irq_lvl) |=> !irq_lvl);
endmodule

// File: tb/tb_codec_frame_ctrl.sv
module tb_codec_frame_ctrl;
  localparam int NC = 16;
  localparam int P  = 512;
  localparam int W  = 6;
  localparam logic [31:0] CA = 32'h8020_0020;

  logic        clk = 1'b0;
  logic        rst;
  logic [31:0] bus_addr, bus_wdata, bus_rdata;
  logic        bus_wr, bus_rd, bus_strb;
  logic [NC-1:0] codec_rst;
  logic        irq;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  bit done   = 0;

  always #2 clk = ~clk;

  codec_frame_ctrl dut (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_strb(bus_strb),
    .bus_rdata(bus_rdata), .codec_rst(codec_rst), .irq(irq)
  );

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual %0d cycles expected below 150000", cyc);
      finish_run();
    end
  end

  // one access cycle; returns at the negedge after the access edge
  task automatic access(input logic [31:0] a, input logic [31:0] d,
                        input logic w, input logic r, input logic s);
    bus_addr = a; bus_wdata = d; bus_wr = w; bus_rd = r; bus_strb = s;
    @(posedge clk);
    @(negedge clk);
    bus_wr = 0; bus_rd = 0; bus_strb = 0; bus_addr = '0; bus_wdata = '0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  // count edges until irq seen high; returns count (or -1 on timeout)
  task automatic wait_irq(output int n);
    n = -1;
    for (int i = 1; i <= 4 * P; i++) begin
      @(posedge clk);
      @(negedge clk);
      if (irq) begin n = i; break; end
    end
  endtask

  task automatic wait_irq_low();
    for (int i = 0; i < 4 * W && irq; i++) idle(1);
  endtask

  task automatic t_reset();
    rst = 1; bus_addr = '0; bus_wdata = '0; bus_wr = 0; bus_rd = 0; bus_strb = 0;
    idle(3);
    chk("R1", "codec_rst in reset", 32'(codec_rst), 32'(16'hFFFF));
    chk("R1", "irq in reset", 32'(irq), 0);
    chk("R1", "rdata in reset", bus_rdata, 0);
    rst = 0;
    idle(1);
    chk("R1", "codec_rst after reset", 32'(codec_rst), 32'(16'hFFFF));
    chk("R1", "irq after reset", 32'(irq), 0);
  endtask

  task automatic t_ignored();
    access(CA + 4, 32'h80, 1, 0, 1);
    chk("R4", "other address write", 32'(codec_rst), 32'(16'hFFFF));
    access(CA, 32'h80, 1, 0, 0);
    chk("R4", "write without strobe", 32'(codec_rst), 32'(16'hFFFF));
    idle(P + 20);
    chk("R4", "no irq while held", 32'(irq), 0);
  endtask

  task automatic t_start_timing();
    int n, w, gap;
    access(CA, 32'h80, 1, 0, 1);
    chk("R2", "all codecs released together", 32'(codec_rst), 0);
    wait_irq(n);
    chk("R5", "first irq latency", 32'(n), 32'(P + 1));
    w = 1;
    for (int i = 0; i < 4 * W; i++) begin
      idle(1);
      if (!irq) break;
      w++;
    end
    chk("R6", "pulse width", 32'(w), 32'(W));
    wait_irq(gap);
    chk("R5", "irq period", 32'(gap + w), 32'(P));
    access(CA + 4, 32'h00, 1, 0, 1);
    chk("R4", "other address stop ignored", 32'(codec_rst), 0);
    access(CA, 32'h00, 1, 0, 1);
    chk("R3", "stop asserts all resets", 32'(codec_rst), 32'(16'hFFFF));
    idle(W + 2);
  endtask

  task automatic t_status();
    int n;
    access(CA, 32'h80, 1, 0, 1);
    wait_irq(n);
    access(CA, 0, 0, 1, 1);
    chk("R7", "left irq status", bus_rdata, 32'h1);
    wait_irq_low();
    access(CA, 0, 0, 1, 1);
    chk("R8", "status between pulses", bus_rdata, 32'h0);
    access(CA + 8, 0, 0, 1, 1);
    chk("R8", "read other address", bus_rdata, 32'h0);
    wait_irq(n);
    access(CA, 0, 0, 1, 0);
    chk("R8", "read without strobe", bus_rdata, 32'h0);
    access(CA, 0, 0, 1, 1);
    chk("R7", "right irq status", bus_rdata, 32'h3);
    wait_irq_low();
    wait_irq(n);
    access(CA, 0, 0, 1, 1);
    chk("R7", "third irq back to left", bus_rdata, 32'h1);
    wait_irq_low();
  endtask

  task automatic t_stop_restart();
    int n;
    bit seen;
    // now in right phase of a running frame: stop partway through
    idle(200);
    access(CA, 32'h00, 1, 0, 1);
    chk("R3", "stop mid-frame", 32'(codec_rst), 32'(16'hFFFF));
    seen = 0;
    for (int i = 0; i < 2 * P; i++) begin
      idle(1);
      if (irq) seen = 1;
    end
    chk("R9", "no irq while stopped", 32'(seen), 0);
    access(CA, 0, 0, 1, 1);
    chk("R9", "stopped status left", bus_rdata, 32'h0);
    access(CA, 32'hFF, 1, 0, 1);
    chk("R2", "restart", 32'(codec_rst), 0);
    wait_irq(n);
    chk("R9", "restart latency", 32'(n), 32'(P + 1));
    access(CA, 0, 0, 1, 1);
    chk("R9", "restart first irq is left", bus_rdata, 32'h1);
    access(CA, 32'h7F, 1, 0, 1);
    chk("R3", "bit7 clear stops", 32'(codec_rst), 32'(16'hFFFF));
  endtask

  initial begin
    t_reset();
    t_ignored();
    t_start_timing();
    t_status();
    t_stop_restart();
    idle(4);
    finish_run();
  end
endmodule